// File: doc/BRIEF.md
# SD/MMC Card Bus Clock Generator

This block produces the clock that an SD/MMC host drives onto the card bus. It derives that clock from the faster module clock and is controlled by one memory-mapped control word. The word holds five fields. An 8-bit divide value sets an even division ratio. A run bit enables the clock. A low-power bit stops the clock whenever the command/data path reports that the bus is idle. A pass-through bit routes the module clock straight to the card. A four-line bit selects the width of the data bus.

Software keeps the divide value large during card identification, so that the card clock stays below 400 kHz. Once every card has been given an address, it may lower the divide value or select pass-through. Every change to a field is applied only while the card clock is low. A high phase is therefore never cut short, and no runt pulse reaches the bus. Besides the clock, the block provides a strobe on the module clock that marks each card clock transition. It also provides a level that tells the data path how many data lines are in use.

The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure, because every access completes in the cycle it is presented.

Top module: `sdclk_gen`

## Requirements
- R1: With pass-through off, the card clock has a period of 2×(N+1) module clock cycles, with equal high and low phases, where N is control bits 7:0.
- R2: While control bit 8 (run) is 0, the card clock stays low.
- R3: While control bit 9 (low-power) is 1 and `bus_idle` is 1, the card clock stays low. When `bus_idle` returns to 0 the clock resumes. With bit 9 at 0, `bus_idle` has no effect.
- R4: While control bit 10 (pass-through) is 1 and the clock runs, the card clock follows the module clock and ignores bits 7:0.
- R5: `wide_bus` equals control bit 11 from the cycle after that bit is written. A 1 means four data lines and a 0 means one data line.
- R6: A read at `CTRL_ADDR` returns the control fields in bits 11:0 and zero in bits 31:12, and writes to bits 31:12 are ignored. A read at any other address returns zero, and a write at any other address changes nothing.
- R7: After reset, all control fields are 0, the card clock is low and `wide_bus` is 0.
- R8: A new divide value first applies to the low phase that follows the current high phase. The current high phase keeps its full length.
- R9: When the clock is stopped during a high phase, that high phase completes at full length before the clock is held low.
- R10: In divided mode, `card_edge` is 1 in exactly the module clock cycles in which the card clock has just changed. In pass-through mode, `card_edge` stays 1 for as long as the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| bus_idle | input | 1 | Command/data path reports an idle bus |
| card_clk | output | 1 | Gated card bus clock |
| card_edge | output | 1 | Marks each card clock transition |
| wide_bus | output | 1 | 1: four data lines, 0: one data line |

## Verification
If the phase counter or the latched divide value is wrong, a high or low phase comes out with the wrong length. This shows up at `card_clk` within a single card clock period. A broken stop path, whether run, low-power or pass-through hand-over, leaves the clock toggling, or truncates a high phase, on the first edge after the control change. A fault in the register decode shows on the very next read, or on `wide_bus` one cycle after the write. A misplaced transition strobe disagrees with `card_clk` in the cycle of the transition.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int DIV_W  = 8;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic             wide;
    logic             byp;
    logic             psave;
    logic             en;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output ctrl_t             ctrl
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic hit;
  assign hit = (reg_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (reg_wr && hit) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  assign reg_rdata = hit ? {{PAD_W{1'b0}}, ctrl} : '0;
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             div_clk,
  output logic             div_stb
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_act;
  logic             term;

  assign term = (cnt == div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_act <= '0;
      div_clk <= 1'b0;
      div_stb <= 1'b0;
    end else begin
      div_stb <= 1'b0;
      if (!div_clk) begin
        if (!run) begin
          // parked low: keep picking up the latest divide value
          cnt     <= '0;
          div_act <= div_cfg;
        end else if (term) begin
          cnt     <= '0;
          div_clk <= 1'b1;
          div_stb <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        // a high phase always runs to its full length
        if (term) begin
          cnt     <= '0;
          div_clk <= 1'b0;
          div_stb <= 1'b1;
          div_act <= div_cfg;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdclk_bypass.sv
module sdclk_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_cfg,
  input  logic run,
  input  logic div_clk,
  output logic byp_act,
  output logic byp_gate
);
  // mode hand-over happens on the rising edge only when both sources are low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_act <= 1'b0;
    else if (!byp_gate && !div_clk) byp_act <= byp_cfg;
  end

  // gate changes while the module clock is low, so clk & gate cannot glitch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_gate <= 1'b0;
    else byp_gate <= byp_act && byp_cfg && run;
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_idle,
  output logic              card_clk,
  output logic              card_edge,
  output logic              wide_bus
);
  ctrl_t ctrl;
  logic  run, div_run, div_clk, div_stb, byp_act, byp_gate;

  sdclk_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl(ctrl)
  );

  assign run     = ctrl.en && !(ctrl.psave && bus_idle);
  assign div_run = run && !ctrl.byp && !byp_act;

  sdclk_div u_div (
    .clk(clk), .rst_n(rst_n), .run(div_run), .div_cfg(ctrl.div),
    .div_clk(div_clk), .div_stb(div_stb)
  );

  sdclk_bypass u_byp (
    .clk(clk), .rst_n(rst_n), .byp_cfg(ctrl.byp), .run(run),
    .div_clk(div_clk), .byp_act(byp_act), .byp_gate(byp_gate)
  );

  assign card_clk  = byp_act ? (clk & byp_gate) : div_clk;
  assign card_edge = div_stb | (byp_act & byp_gate);
  assign wide_bus  = ctrl.wide;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              bus_idle,
  input logic              card_edge,
  input logic              wide_bus,
  input logic              div_clk,
  input logic              byp_act,
  input logic              byp_gate,
  input logic              en_q,
  input logic              psave_q
);
  p_wide_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CTRL_ADDR) |=> (wide_bus == $past(reg_wdata[11])));

  p_other_addr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != CTRL_ADDR) |-> (reg_rdata == 32'h0));

  p_off_stays_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !div_clk) |=> !div_clk);

  p_idle_stays_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && psave_q && bus_idle && !div_clk) |=> !div_clk);

  p_edge_marked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_clk != $past(div_clk)) |-> card_edge);

  p_clean_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byp_act) |-> ($past(!byp_gate) && $past(!div_clk)));
endmodule

bind sdclk_gen sdclk_gen_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_idle(bus_idle),
  .card_edge(card_edge), .wide_bus(wide_bus), .div_clk(div_clk),
  .byp_act(byp_act), .byp_gate(byp_gate), .en_q(ctrl.en), .psave_q(ctrl.psave)
);

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;
  localparam logic [3:0] CA = 4'h4;
  localparam logic [3:0] OA = 4'h0;
  localparam logic [31:0] EN = 32'h100, PS = 32'h200, BY = 32'h400, WD = 32'h800;
  // {divide value, expected cycles per phase}
  localparam logic [15:0] VEC [5] = '{16'h0001, 16'h0102, 16'h0203, 16'h0506, 16'h090A};

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, bus_idle = 1'b0;
  logic [3:0]  reg_addr = CA;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic card_clk, card_edge, wide_bus;
  int checks = 0, errors = 0, edge_err = 0;
  int hi, lo;

  always #5 clk = ~clk;

  sdclk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_idle(bus_idle),
    .card_clk(card_clk), .card_edge(card_edge), .wide_bus(wide_bus)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = CA;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_addr = CA;
  endtask

  // Wait for a rising card clock, count the high phase and the following low phase.
  // When the high count reaches wr_at (>0), write wr_val to the control word.
  task automatic phase(input int wr_at, input logic [31:0] wr_val, output int h, output int l);
    logic prev, cur;
    int guard = 0;
    h = 0; l = 0;
    @(posedge clk); #1 prev = card_clk;
    do begin
      @(posedge clk); #1 cur = card_clk;
      if ((cur != prev) != card_edge) edge_err++;
      if (!(cur && !prev)) prev = cur;
      guard++;
    end while (!(cur && !prev) && guard < 600);
    if (guard >= 600) return;
    prev = cur;
    while (cur && h < 600) begin
      h++;
      if (wr_at > 0 && h == wr_at) begin reg_addr = CA; reg_wdata = wr_val; reg_wr = 1'b1; end
      @(posedge clk); #1 reg_wr = 1'b0; cur = card_clk;
      if ((cur != prev) != card_edge) edge_err++;
      prev = cur;
    end
    while (!cur && l < 300) begin
      l++;
      @(posedge clk); #1 cur = card_clk;
      if ((cur != prev) != card_edge) edge_err++;
      prev = cur;
    end
  endtask

  task automatic stays_low(input string req, input int n);
    int toggles = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 if (card_clk) toggles++;
    end
    check(req, toggles, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1;
    check("R7 card_clk", card_clk, 0);
    check("R7 wide_bus", wide_bus, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(CA, d); check("R7 ctrl readback", d, 0);
    stays_low("R2 no run after reset", 30);

    // R1 / R10: divided periods from the vector table
    foreach (VEC[i]) begin
      wr(CA, EN | 32'(VEC[i][15:8]));
      phase(0, '0, hi, lo);
      phase(0, '0, hi, lo);
      check($sformatf("R1 high div=%0d", VEC[i][15:8]), hi, VEC[i][7:0]);
      check($sformatf("R1 low div=%0d", VEC[i][15:8]), lo, VEC[i][7:0]);
    end
    check("R10 strobe matches edges", edge_err, 0);

    // R8: new divide value waits for the next low phase
    wr(CA, EN | 32'd9);
    phase(0, '0, hi, lo);
    phase(2, EN | 32'd0, hi, lo);
    check("R8 high kept full length", hi, 10);
    check("R8 new value in low phase", lo, 1);

    // R9: stop during a high phase
    wr(CA, EN | 32'd4);
    phase(0, '0, hi, lo);
    phase(2, 32'd0, hi, lo);
    check("R9 high completes", hi, 5);
    check("R9 then held low", lo, 300);
    stays_low("R2 run bit clear", 40);

    // R3: low-power gating by bus_idle
    bus_idle = 1'b1;
    wr(CA, EN | PS | 32'd1);
    repeat (6) @(posedge clk);
    stays_low("R3 idle stops clock", 40);
    bus_idle = 1'b0;
    phase(0, '0, hi, lo);
    check("R3 resumes when busy", hi + lo, 4);
    wr(CA, EN | 32'd1);
    bus_idle = 1'b1;
    phase(0, '0, hi, lo);
    check("R3 idle ignored without low-power", hi + lo, 4);
    bus_idle = 1'b0;

    // R4: pass-through follows the module clock, divide ignored
    wr(CA, EN | BY | 32'd200);
    repeat (8) @(posedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(posedge clk); #2 if (card_clk !== 1'b1 || card_edge !== 1'b1) bad++;
        @(negedge clk); #2 if (card_clk !== 1'b0) bad++;
      end
      check("R4 follows module clock", bad, 0);
    end
    wr(CA, BY);
    repeat (4) @(posedge clk);
    stays_low("R4 pass-through stopped", 20);
    edge_err = 0;
    wr(CA, EN | 32'd1);
    phase(0, '0, hi, lo);
    phase(0, '0, hi, lo);
    check("R4 leaves pass-through cleanly", hi * 16 + lo, 16'h22);
    check("R10 strobe after pass-through", edge_err, 0);

    // R5 / R6: decode
    wr(CA, WD);
    #1 check("R5 wide set", wide_bus, 1);
    wr(CA, 32'hFFFF_F023);
    rd(CA, d); check("R6 upper bits ignored", d, 32'h023);
    check("R5 wide cleared", wide_bus, 0);
    wr(OA, 32'hFFFF_FFFF);
    rd(CA, d); check("R6 other address write ignored", d, 32'h023);
    check("R6 wide untouched", wide_bus, 0);
    rd(OA, d); check("R6 other address reads zero", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule